// File: doc/BRIEF.md
# Averaging Phase-Select Interpolation Controller

This block steers the feedback-clock phase selector of a multi-phase PLL. It accepts a 7-bit phase code once per reference-clock cycle. The upper five bits name a base phase index n. The lower two bits name a fraction of one phase step. Over a fixed four-cycle window the block chooses either n or the index above it for each cycle. The loop filter averages these choices into a quarter, half or three-quarter step between the two phases.

In every cycle the chosen 5-bit index is decoded into drive signals for the phase multiplexers and the interpolator:
- one select bit for each of the two neighbouring-phase multiplexers;
- an inversion flag applied to both multiplexer outputs;
- a thermometer-coded weight for the current-mode interpolator.

The averaging mode and the current-mode interpolation can each be switched off on their own. All outputs are registered on the reference clock.

Top module: `phase_avg_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), mux_a_o, mux_b_o, invert_o and therm_o are all 0.
- R2: The code is split as code_i[6:2] = base index n and code_i[1:0] = fraction. The selected index k is decoded as mux_a_o = k[2], mux_b_o = k[3] and invert_o = k[4].
- R3: Outputs are registered. The window position (slot) counts 0,1,2,3 and then repeats. The first clock edge after reset is released produces slot 0.
- R4: code_i, avg_en_i and cmi_en_i are sampled only at the slot-0 edge. Changes in slots 1 to 3 have no effect until the next window.
- R5: With averaging on, the slots that select n+1 depend on the fraction as follows. Fraction 0 selects n+1 in no slot. Fraction 1 selects it in slot 3. Fraction 2 selects it in slots 1 and 3. Fraction 3 selects it in slots 1, 2 and 3. Every other slot selects n.
- R6: n+1 is computed modulo 32, so base index 31 selects index 0 in its upper slots.
- R7: With current-mode interpolation on, the fine value f = k[1:0] drives therm_o with f ones filled from bit 0 (0→0000, 1→0001, 2→0011, 3→0111).
- R8: With current-mode interpolation off (cmi_en_i = 0), therm_o is 0000 in every slot.
- R9: With averaging off (avg_en_i = 0), the fraction bits are ignored and n is selected in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | 7 | Phase code: base index in the upper 5 bits, fraction in the lower 2 |
| avg_en_i | input | 1 | Enables averaging across the four-cycle window |
| cmi_en_i | input | 1 | Enables the current-mode interpolator weight |
| mux_a_o | output | 1 | Select for the first phase multiplexer |
| mux_b_o | output | 1 | Select for the second phase multiplexer |
| invert_o | output | 1 | Inverts both multiplexer outputs |
| therm_o | output | 4 | Thermometer-coded interpolator weight |

## Verification
The bench applies the four fraction values to one base index. The slot-by-slot outputs then show whether each fraction yields its own set of upper-index slots, rather than a rotated or shifted pattern. Base index 31 with fraction 3 shows whether the upper index wraps to 0 or spills into the wrong coarse bits. Several base indices are run with averaging off to show that each coarse and fine bit lands on its own output. A window whose code is overwritten after slot 0, and windows with either enable cleared, show whether late inputs and the disable paths are ignored or followed.

// File: rtl/pasel_pkg.sv
package pasel_pkg;

    localparam int DEF_IDX_W  = 5;
    localparam int DEF_FRAC_W = 2;
    localparam int DEF_FINE_W = 2;

    // Upper index is chosen when a running sum of the fraction carries
    // out of the window modulus in this slot.
    function automatic logic pick_upper(input int unsigned slot,
                                        input int unsigned frac,
                                        input int unsigned win);
        return (((slot * frac) % win) + frac) >= win;
    endfunction

endpackage

// File: rtl/pasel_seq.sv
module pasel_seq #(
    parameter int FRAC_W = pasel_pkg::DEF_FRAC_W
) (
    input  logic [FRAC_W-1:0] slot_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              avg_en_i,
    output logic              pick_up_o
);
    localparam int WIN = 1 << FRAC_W;

    always_comb begin
        pick_up_o = avg_en_i &&
                    pasel_pkg::pick_upper(int'(slot_i), int'(frac_i), WIN);
    end
endmodule

// File: rtl/pasel_decode.sv
module pasel_decode #(
    parameter int IDX_W  = pasel_pkg::DEF_IDX_W,
    parameter int FINE_W = pasel_pkg::DEF_FINE_W
) (
    input  logic [IDX_W-1:0]         idx_i,
    input  logic                     cmi_en_i,
    output logic                     mux_a_o,
    output logic                     mux_b_o,
    output logic                     invert_o,
    output logic [(1<<FINE_W)-1:0]   therm_o
);
    localparam int THERM_W = 1 << FINE_W;

    logic [FINE_W-1:0] fine;

    // Coarse field is idx_i[IDX_W-1:FINE_W]; three bits in this arrangement.
    assign fine     = idx_i[FINE_W-1:0];
    assign mux_a_o  = idx_i[FINE_W];
    assign mux_b_o  = idx_i[FINE_W+1];
    assign invert_o = idx_i[IDX_W-1];

    for (genvar i = 0; i < THERM_W; i++) begin : g_therm
        assign therm_o[i] = cmi_en_i && (int'(fine) > i);
    end
endmodule

// File: rtl/phase_avg_ctrl.sv
module phase_avg_ctrl #(
    parameter int IDX_W  = pasel_pkg::DEF_IDX_W,
    parameter int FRAC_W = pasel_pkg::DEF_FRAC_W,
    parameter int FINE_W = pasel_pkg::DEF_FINE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W+FRAC_W-1:0]    code_i,
    input  logic                       avg_en_i,
    input  logic                       cmi_en_i,
    output logic                       mux_a_o,
    output logic                       mux_b_o,
    output logic                       invert_o,
    output logic [(1<<FINE_W)-1:0]     therm_o
);
    localparam int CODE_W  = IDX_W + FRAC_W;
    localparam int THERM_W = 1 << FINE_W;

    typedef struct packed {
        logic [FRAC_W-1:0]  slot;
        logic [CODE_W-1:0]  code;
        logic               avg;
        logic               cmi;
        logic               mux_a;
        logic               mux_b;
        logic               inv;
        logic [THERM_W-1:0] therm;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0]  eff_code;
    logic               eff_avg;
    logic               eff_cmi;
    logic [IDX_W-1:0]   base_idx;
    logic [IDX_W-1:0]   sel_idx;
    logic               pick_up;
    logic               dec_mux_a;
    logic               dec_mux_b;
    logic               dec_inv;
    logic [THERM_W-1:0] dec_therm;

    // Window start takes the live inputs; later slots use the held copy.
    always_comb begin
        if (st_q.slot == '0) begin
            eff_code = code_i;
            eff_avg  = avg_en_i;
            eff_cmi  = cmi_en_i;
        end else begin
            eff_code = st_q.code;
            eff_avg  = st_q.avg;
            eff_cmi  = st_q.cmi;
        end
        base_idx = eff_code[CODE_W-1:FRAC_W];
        sel_idx  = pick_up ? base_idx + IDX_W'(1) : base_idx;
    end

    pasel_seq #(.FRAC_W(FRAC_W)) u_seq (
        .slot_i    (st_q.slot),
        .frac_i    (eff_code[FRAC_W-1:0]),
        .avg_en_i  (eff_avg),
        .pick_up_o (pick_up)
    );

    pasel_decode #(.IDX_W(IDX_W), .FINE_W(FINE_W)) u_dec (
        .idx_i    (sel_idx),
        .cmi_en_i (eff_cmi),
        .mux_a_o  (dec_mux_a),
        .mux_b_o  (dec_mux_b),
        .invert_o (dec_inv),
        .therm_o  (dec_therm)
    );

    always_comb begin
        st_d       = st_q;
        st_d.slot  = st_q.slot + FRAC_W'(1);
        st_d.code  = eff_code;
        st_d.avg   = eff_avg;
        st_d.cmi   = eff_cmi;
        st_d.mux_a = dec_mux_a;
        st_d.mux_b = dec_mux_b;
        st_d.inv   = dec_inv;
        st_d.therm = dec_therm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_a_o  = st_q.mux_a;
    assign mux_b_o  = st_q.mux_b;
    assign invert_o = st_q.inv;
    assign therm_o  = st_q.therm;
endmodule

// File: rtl/pasel_chk.sv
module pasel_chk #(
    parameter int FRAC_W  = 2,
    parameter int CODE_W  = 7,
    parameter int THERM_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FRAC_W-1:0]  slot,
    input logic [CODE_W-1:0]  hold_code,
    input logic               hold_cmi,
    input logic [THERM_W-1:0] therm
);
    // R3: window position advances by one each cycle, wrapping at the window size
    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot == FRAC_W'($past(slot) + FRAC_W'(1)));

    // R4: held code only changes at a window start
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != '0) |=> $stable(hold_code));

    // R7: weight is always a thermometer code below the top bit
    a_r7_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm & THERM_W'(therm + 1'b1)) == '0) && !therm[THERM_W-1]);

    // R8: interpolation disabled gives a zero weight
    a_r8_cmi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != '0 && !hold_cmi) |=> (therm == '0));
endmodule

bind phase_avg_ctrl pasel_chk #(
    .FRAC_W  (FRAC_W),
    .CODE_W  (CODE_W),
    .THERM_W (THERM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (st_q.slot),
    .hold_code (st_q.code),
    .hold_cmi  (st_q.cmi),
    .therm     (therm_o)
);

// File: tb/phase_avg_ctrl_test.sv
`timescale 1ns/1ps
module phase_avg_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] code_i = '0;
    logic       avg_en_i = 1'b0;
    logic       cmi_en_i = 1'b0;
    logic       mux_a_o, mux_b_o, invert_o;
    logic [3:0] therm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [6:0] bits;   // {mux_a, mux_b, invert, therm}
        int         slot;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    phase_avg_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (code_i),
        .avg_en_i (avg_en_i),
        .cmi_en_i (cmi_en_i),
        .mux_a_o  (mux_a_o),
        .mux_b_o  (mux_b_o),
        .invert_o (invert_o),
        .therm_o  (therm_o)
    );

    function automatic bit upper_slot(int frac, int slot);
        case (frac)
            0:       return 1'b0;
            1:       return slot == 3;
            2:       return slot == 1 || slot == 3;
            default: return slot != 0;
        endcase
    endfunction

    function automatic logic [6:0] expect_bits(logic [6:0] code, bit avg,
                                               bit cmi, int slot);
        logic [4:0] k;
        logic [3:0] th;
        k = code[6:2];
        if (avg && upper_slot(int'(code[1:0]), slot)) k = k + 5'd1;
        case (k[1:0])
            2'd0: th = 4'b0000;
            2'd1: th = 4'b0001;
            2'd2: th = 4'b0011;
            default: th = 4'b0111;
        endcase
        if (!cmi) th = 4'b0000;
        return {k[2], k[3], k[4], th};
    endfunction

    // Driver: called at a negative edge just before a window's slot-0 edge.
    task automatic run_window(logic [6:0] code, bit avg, bit cmi,
                              bit disturb, string req);
        code_i   = code;
        avg_en_i = avg;
        cmi_en_i = cmi;
        for (int s = 0; s < 4; s++) begin
            exp_t e;
            e.bits = expect_bits(code, avg, cmi, s);
            e.slot = s;
            e.req  = req;
            sb.push_back(e);
        end
        @(negedge clk);
        if (disturb) begin
            code_i   = ~code;
            avg_en_i = ~avg;
            cmi_en_i = ~cmi;
        end
        repeat (3) @(negedge clk);
    endtask

    // Monitor: outputs settle after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                logic [6:0] got;
                e   = sb.pop_front();
                got = {mux_a_o, mux_b_o, invert_o, therm_o};
                checks++;
                if (got !== e.bits) begin
                    fails++;
                    $display("FAIL %s slot %0d: got %b expected %b",
                             e.req, e.slot, got, e.bits);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({mux_a_o, mux_b_o, invert_o, therm_o} !== 7'b0) begin
            fails++;
            $display("FAIL R1 reset: got %b expected %b",
                     {mux_a_o, mux_b_o, invert_o, therm_o}, 7'b0);
        end
        rst_n = 1'b1;

        // R2 / R3: coarse field decode, averaging off
        run_window({5'd5, 2'd3},  1'b0, 1'b1, 1'b0, "R2");
        run_window({5'd22, 2'd0}, 1'b0, 1'b1, 1'b0, "R2");
        run_window({5'd9, 2'd0},  1'b1, 1'b1, 1'b0, "R3");
        // R5: each fraction pattern on one base index
        run_window({5'd9, 2'd1},  1'b1, 1'b1, 1'b0, "R5");
        run_window({5'd9, 2'd2},  1'b1, 1'b1, 1'b0, "R5");
        run_window({5'd9, 2'd3},  1'b1, 1'b1, 1'b0, "R5");
        run_window({5'd14, 2'd2}, 1'b1, 1'b0, 1'b0, "R5");
        // R6: wrap of the upper index
        run_window({5'd31, 2'd3}, 1'b1, 1'b1, 1'b0, "R6");
        run_window({5'd31, 2'd1}, 1'b1, 1'b0, 1'b0, "R6");
        // R7: each fine value on the weight
        run_window({5'd4, 2'd0},  1'b0, 1'b1, 1'b0, "R7");
        run_window({5'd6, 2'd0},  1'b0, 1'b1, 1'b0, "R7");
        run_window({5'd7, 2'd0},  1'b0, 1'b1, 1'b0, "R7");
        run_window({5'd3, 2'd3},  1'b1, 1'b1, 1'b0, "R7");
        // R8: interpolation weight disabled
        run_window({5'd7, 2'd2},  1'b1, 1'b0, 1'b0, "R8");
        // R9: fraction ignored with averaging off
        run_window({5'd30, 2'd2}, 1'b0, 1'b1, 1'b0, "R9");
        run_window({5'd31, 2'd3}, 1'b0, 1'b1, 1'b0, "R9");
        // R4: inputs overwritten after slot 0 must not take effect
        run_window({5'd12, 2'd1}, 1'b1, 1'b1, 1'b1, "R4");
        run_window({5'd31, 2'd2}, 1'b1, 1'b0, 1'b1, "R4");
        run_window({5'd0, 2'd3},  1'b0, 1'b1, 1'b1, "R4");

        repeat (2) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R3 scoreboard: got %0d left expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

endmodule